// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block decides which of five request sources is handed to the processor and when. The sources are two external event inputs, two timer overflow inputs and a serial port whose receive and transmit flags are level signals. Software sets a global enable, per-source enables and a per-source priority level (high or low) through a small write port. When a request may be taken, the controller pulses `irq_o` for one cycle. In that same cycle it presents the source's fixed entry address on `vec_o` and pulses that source's bit of `ack_o`.

The block keeps one in-service flag for each level. A high-level request may interrupt a low-level handler. A low-level request never interrupts a high-level handler, and no request interrupts a handler of its own level. The processor signals the end of a handler with a one-cycle `reti_i` pulse, which retires the most senior level that is in service.

The external and timer sources are held in internal pending flags, and the acknowledge clears them. The serial source follows its flags directly, so software must clear those flags itself. Reset vectoring happens outside this block; only the reset address 0000h appears, as the value `vec_o` holds after reset.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_o` and `ack_o` are 0 and `vec_o` is 0000h. All enables and priority bits are 0 and neither level is in service.
- R2: A source is granted only when the global enable (enable register bit 7) and its own enable bit are both 1. The enable bits are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. A request that arrives while its source is disabled stays pending and is granted once enabled.
- R3: The entry addresses are 0003h for external 0, 000Bh for timer 0, 0013h for external 1, 001Bh for timer 1 and 0023h for serial.
- R4: A grant is a single cycle with `irq_o` = 1, exactly one `ack_o` bit set (bit index = source number, in the order of R2) and `vec_o` = that source's address. The grant comes two clock edges after the request input is sampled high.
- R5: The pending flags of the external and timer sources are cleared by their acknowledge. An event that arrives in the same cycle as the acknowledge is kept and is served later.
- R6: The serial source requests while its receive flag or its transmit flag is high. An acknowledge does not clear either flag, so a request that is still asserted is served again after the handler returns.
- R7: Priority register bit n puts source n at the high level (1) or the low level (0). A high-level request beats any low-level one. Within one level, lower source numbers win.
- R8: A pending high-level request is granted while a low-level handler is in service.
- R9: No request is granted while a high-level handler is in service. A low-level request is not granted while a low-level handler is in service.
- R10: A grant marks its level in service. `reti_i` clears the high in-service flag if it is set, otherwise the low one. Requests that were held back are then served.
- R11: A write with `wr_sel_i` = 0 loads the enable register, and a write with `wr_sel_i` = 1 loads the priority register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext0_evt_i | input | 1 | Event pulse from external source 0 |
| tmr0_ovf_i | input | 1 | Overflow pulse from timer 0 |
| ext1_evt_i | input | 1 | Event pulse from external source 1 |
| tmr1_ovf_i | input | 1 | Overflow pulse from timer 1 |
| ser_rx_i | input | 1 | Serial receive flag (level) |
| ser_tx_i | input | 1 | Serial transmit flag (level) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = enable register, 1 = priority register |
| wr_data_i | input | DATA_W | Write data |
| reti_i | input | 1 | End-of-handler pulse |
| irq_o | output | 1 | One-cycle grant to the processor |
| vec_o | output | ADDR_W | Entry address of the granted source |
| ack_o | output | 5 | One-hot acknowledge to the granted source |

## Verification
A source's acknowledge (which clears its pending flag) and a new event from that same source can land on the same clock edge. The update has to let the new event survive rather than lose it. The bench provokes this by holding an external event input high across the grant edge. It judges the result by seeing the grant once, seeing no further grant while that level is in service, and seeing a second grant with the same address after `reti_i`.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   localparam int unsigned SRC_CNT = 5;

   typedef enum logic [2:0] {
      SRC_EXT0 = 3'd0,
      SRC_TMR0 = 3'd1,
      SRC_EXT1 = 3'd2,
      SRC_TMR1 = 3'd3,
      SRC_SER  = 3'd4
   } src_id_e;

   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } level_e;

   typedef enum logic {
      SEL_ENABLE = 1'b0,
      SEL_PRIO   = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/irq_src_flag.sv
// Pending state of one source. KEEP=1 holds the event until it is
// acknowledged (a new event beats the clear); KEEP=0 just samples a level.
module irq_src_flag #(
   parameter bit KEEP = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic clr_i,
   output logic pend_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o <= 1'b0;
      else        pend_o <= evt_i | (KEEP & pend_o & ~clr_i);
   end
endmodule

// File: rtl/irq_pick.sv
// Two-level fixed-order selection among enabled candidates.
module irq_pick import prio_irq_pkg::*; #(
   parameter int unsigned N     = SRC_CNT,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     cand_i,
   input  logic [N-1:0]     hi_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] idx_o,
   output level_e           lvl_o
);
   logic [N-1:0] hi_set, lo_set, use_set;

   always_comb begin
      hi_set  = cand_i & hi_i;
      lo_set  = cand_i & ~hi_i;
      lvl_o   = (hi_set != '0) ? LVL_HIGH : LVL_LOW;
      use_set = (hi_set != '0) ? hi_set : lo_set;
      valid_o = (cand_i != '0);
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (use_set[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_nest.sv
// In-service flags for the two levels.
module irq_nest import prio_irq_pkg::*; (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   take_i,
   input  level_e take_lvl_i,
   input  logic   reti_i,
   output logic   in_hi_o,
   output logic   in_lo_o
);
   logic ret_hi, ret_lo;

   always_comb begin
      ret_hi = reti_i & in_hi_o;
      ret_lo = reti_i & ~in_hi_o & in_lo_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_hi_o <= 1'b0;
         in_lo_o <= 1'b0;
      end else begin
         in_hi_o <= (in_hi_o & ~ret_hi) | (take_i & (take_lvl_i == LVL_HIGH));
         in_lo_o <= (in_lo_o & ~ret_lo) | (take_i & (take_lvl_i == LVL_LOW));
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl import prio_irq_pkg::*; #(
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned VEC_BASE      = 3,
   parameter int unsigned VEC_STRIDE    = 8,
   parameter int unsigned GLOBAL_EN_BIT = 7,
   parameter int unsigned RESET_VEC     = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ext0_evt_i,
   input  logic               tmr0_ovf_i,
   input  logic               ext1_evt_i,
   input  logic               tmr1_ovf_i,
   input  logic               ser_rx_i,
   input  logic               ser_tx_i,
   input  logic               wr_en_i,
   input  logic               wr_sel_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   input  logic               reti_i,
   output logic               irq_o,
   output logic [ADDR_W-1:0]  vec_o,
   output logic [SRC_CNT-1:0] ack_o
);
   localparam int unsigned IDX_W    = $clog2(SRC_CNT);
   localparam int unsigned LAST_VEC = VEC_BASE + VEC_STRIDE * (SRC_CNT - 1);

   if (GLOBAL_EN_BIT < SRC_CNT || GLOBAL_EN_BIT >= DATA_W) begin : g_bad_ea
      $error("global enable bit must sit above the source bits and inside the data word");
   end
   if (LAST_VEC >= (64'd1 << ADDR_W) || RESET_VEC >= (64'd1 << ADDR_W)) begin : g_bad_vec
      $error("entry addresses do not fit in ADDR_W bits");
   end

   // configuration registers
   logic               ea_q;
   logic [SRC_CNT-1:0] en_q;
   logic [SRC_CNT-1:0] pr_q;
   logic               unused_wr_bits;

   assign unused_wr_bits = ^wr_data_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_q <= 1'b0;
         en_q <= '0;
         pr_q <= '0;
      end else if (wr_en_i) begin
         if (reg_sel_e'(wr_sel_i) == SEL_ENABLE) begin
            ea_q <= wr_data_i[GLOBAL_EN_BIT];
            en_q <= wr_data_i[SRC_CNT-1:0];
         end else begin
            pr_q <= wr_data_i[SRC_CNT-1:0];
         end
      end
   end

   // per-source pending state
   logic [SRC_CNT-1:0] evt, pend, clr;

   always_comb begin
      evt           = '0;
      evt[SRC_EXT0] = ext0_evt_i;
      evt[SRC_TMR0] = tmr0_ovf_i;
      evt[SRC_EXT1] = ext1_evt_i;
      evt[SRC_TMR1] = tmr1_ovf_i;
      evt[SRC_SER]  = ser_rx_i | ser_tx_i;
   end

   for (genvar g = 0; g < SRC_CNT; g++) begin : g_src
      if (g == int'(SRC_SER)) begin : g_level
         irq_src_flag #(.KEEP(1'b0)) u_flag (
            .clk(clk), .rst_n(rst_n), .evt_i(evt[g]), .clr_i(clr[g]), .pend_o(pend[g]));
      end else begin : g_latched
         irq_src_flag #(.KEEP(1'b1)) u_flag (
            .clk(clk), .rst_n(rst_n), .evt_i(evt[g]), .clr_i(clr[g]), .pend_o(pend[g]));
      end
   end

   // selection and nesting decision
   logic [SRC_CNT-1:0] cand;
   logic               win_valid;
   logic [IDX_W-1:0]   win_idx;
   level_e             win_lvl;
   logic               in_hi, in_lo;
   logic               take;

   assign cand = pend & en_q & {SRC_CNT{ea_q}};

   irq_pick #(.N(SRC_CNT)) u_pick (
      .cand_i(cand), .hi_i(pr_q),
      .valid_o(win_valid), .idx_o(win_idx), .lvl_o(win_lvl));

   always_comb begin
      take = win_valid & ~in_hi & ((win_lvl == LVL_HIGH) | ~in_lo);
      clr  = '0;
      if (take) clr[win_idx] = 1'b1;
   end

   irq_nest u_nest (
      .clk(clk), .rst_n(rst_n), .take_i(take), .take_lvl_i(win_lvl),
      .reti_i(reti_i), .in_hi_o(in_hi), .in_lo_o(in_lo));

   // grant outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
         ack_o <= '0;
         vec_o <= ADDR_W'(RESET_VEC);
      end else begin
         irq_o <= take;
         ack_o <= clr;
         if (take) vec_o <= ADDR_W'(VEC_BASE + VEC_STRIDE * int'(win_idx));
      end
   end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk import prio_irq_pkg::*; #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               irq_o,
   input logic [ADDR_W-1:0]  vec_o,
   input logic [SRC_CNT-1:0] ack_o,
   input logic               reti_i,
   input logic               ea_q,
   input logic [SRC_CNT-1:0] pr_q,
   input logic               in_hi,
   input logic               in_lo
);
   logic [ADDR_W-1:0] exp_vec;

   always_comb begin
      exp_vec = '0;
      for (int i = 0; i < int'(SRC_CNT); i++) begin
         if (ack_o[i]) exp_vec = ADDR_W'(VEC_BASE + VEC_STRIDE * i);
      end
   end

   AST_SINGLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($countones(ack_o) == 1)); // R4
   AST_ACK_ONLY_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o != '0) |-> irq_o); // R4
   AST_ENTRY_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (vec_o == exp_vec)); // R3
   AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(ea_q)); // R2
   AST_HIGH_NEVER_PREEMPTED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !$past(in_hi)); // R9
   AST_LOW_WAITS_FOR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && ((ack_o & $past(pr_q)) == '0)) |-> !$past(in_lo)); // R9
   AST_HIGH_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && ((ack_o & $past(pr_q)) != '0)) |-> in_hi); // R8
   AST_RETI_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && in_hi) |=> !in_hi); // R10
   AST_RETI_LOW_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && !in_hi && in_lo) |=> !in_lo); // R10
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
   .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .vec_o(vec_o), .ack_o(ack_o),
   .reti_i(reti_i), .ea_q(ea_q), .pr_q(pr_q), .in_hi(in_hi), .in_lo(in_lo)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext0 = 0, tmr0 = 0, ext1 = 0, tmr1 = 0, srx = 0, stx = 0;
   logic        wr_en = 0, wr_sel = 0, reti = 0;
   logic [7:0]  wr_data = '0;
   logic        irq;
   logic [15:0] vec;
   logic [4:0]  ack;
   int          n_chk = 0, n_fail = 0;
   bit          done = 0;

   always #10 clk = ~clk;

   prio_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ext0_evt_i(ext0), .tmr0_ovf_i(tmr0),
      .ext1_evt_i(ext1), .tmr1_ovf_i(tmr1), .ser_rx_i(srx), .ser_tx_i(stx),
      .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .reti_i(reti),
      .irq_o(irq), .vec_o(vec), .ack_o(ack));

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic write_reg(logic sel, logic [7:0] d);
      wr_en = 1; wr_sel = sel; wr_data = d;
      step();
      wr_en = 0;
   endtask

   task automatic fire(logic [3:0] m); // bit0 ext0, bit1 tmr0, bit2 ext1, bit3 tmr1
      {tmr1, ext1, tmr0, ext0} = m;
      step();
      {tmr1, ext1, tmr0, ext0} = 4'b0;
   endtask

   task automatic do_reti();
      reti = 1;
      step();
      reti = 0;
   endtask

   task automatic expect_grant(string req, int src);
      step();
      check(req, "irq", 32'(irq), 1);
      check(req, "ack", 32'(ack), 32'(1 << src));
      check(req, "vec", 32'(vec), 32'(3 + 8 * src));
   endtask

   task automatic expect_idle(string req, int n);
      for (int i = 0; i < n; i++) begin
         step();
         check(req, "irq idle", 32'(irq), 0);
         check(req, "ack idle", 32'(ack), 0);
      end
   endtask

   task automatic t_reset();
      check("R1", "irq after reset", 32'(irq), 0);
      check("R1", "ack after reset", 32'(ack), 0);
      check("R1", "vec after reset", 32'(vec), 32'h0000);
   endtask

   task automatic t_enables();
      write_reg(1'b1, 8'h00);
      write_reg(1'b0, 8'h1F);        // R2: sources on, global off
      fire(4'b0001);
      expect_idle("R2", 3);
      write_reg(1'b0, 8'h9F);        // R11: enable register written
      expect_grant("R2", 0);
      expect_idle("R4", 1);
      do_reti();
      expect_idle("R5", 3);          // flag cleared by acknowledge
      write_reg(1'b0, 8'h9E);        // ext0 individually off
      fire(4'b0001);
      expect_idle("R2", 3);
      write_reg(1'b0, 8'h9F);
      expect_grant("R2", 0);
      do_reti();
   endtask

   task automatic t_vectors();
      for (int s = 0; s < 4; s++) begin
         fire(4'(1 << s));
         expect_grant("R3", s);
         do_reti();
      end
   endtask

   task automatic t_serial();
      srx = 1;
      step();
      expect_grant("R6", 4);
      expect_idle("R6", 2);
      do_reti();
      expect_grant("R6", 4);         // rx still high: served again
      srx = 0;
      step();
      do_reti();
      expect_idle("R6", 3);
      stx = 1;
      step();
      expect_grant("R6", 4);
      stx = 0;
      step();
      do_reti();
      expect_idle("R6", 2);
   endtask

   task automatic t_order();
      write_reg(1'b1, 8'h00);
      fire(4'b1111);
      expect_grant("R7", 0);
      expect_idle("R9", 2);
      for (int s = 1; s < 4; s++) begin
         do_reti();
         expect_grant("R7", s);
      end
      do_reti();
      expect_idle("R7", 2);
      write_reg(1'b1, 8'h18);        // R11: timer 1 and serial high
      srx = 1;
      fire(4'b1111);
      expect_grant("R7", 3);
      expect_idle("R9", 2);
      do_reti();
      expect_grant("R7", 4);
      srx = 0;
      step();
      do_reti();
      expect_grant("R7", 0);
      do_reti();
      expect_grant("R7", 1);
      do_reti();
      expect_grant("R7", 2);
      do_reti();
      expect_idle("R7", 2);
   endtask

   task automatic t_nesting();
      write_reg(1'b1, 8'h08);        // timer 1 high
      fire(4'b0001);
      expect_grant("R8", 0);
      fire(4'b1000);
      expect_grant("R8", 3);         // preempts low handler
      fire(4'b0100);
      expect_idle("R9", 3);          // low cannot enter high handler
      do_reti();
      expect_idle("R10", 3);         // low still in service
      do_reti();
      expect_grant("R10", 2);
      do_reti();
      write_reg(1'b1, 8'h0A);        // both timers high
      fire(4'b0010);
      expect_grant("R9", 1);
      fire(4'b1000);
      expect_idle("R9", 3);          // same level waits
      do_reti();
      expect_grant("R10", 3);
      do_reti();
      expect_idle("R10", 2);
   endtask

   task automatic t_set_vs_ack();
      write_reg(1'b1, 8'h00);
      ext0 = 1;
      step();
      step();                        // ext0 high on the grant edge
      ext0 = 0;
      check("R5", "irq at grant", 32'(irq), 1);
      check("R5", "ack at grant", 32'(ack), 32'h01);
      expect_idle("R5", 2);
      do_reti();
      expect_grant("R5", 0);         // the late event survived
      do_reti();
      expect_idle("R5", 2);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      t_reset();
      t_enables();
      t_vectors();
      t_serial();
      t_order();
      t_nesting();
      t_set_vs_ack();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule